// File: doc/BRIEF.md
# Push-Button Single-Shot Serial Character Sender

This block sends one 8-bit character on an asynchronous serial transmit line each time a mechanical push button is pressed. The character is taken from an 8-bit parallel input at the moment the frame begins. The raw button first passes through a two-flop synchroniser. A stability-timer debouncer then filters it, and a rising-edge detector turns the filtered level into a one-clock send request. A baud-timed transmit state machine serialises the byte. Because the request comes from the press edge and not from the button level, holding the button down for any length of time gives exactly one frame.

All logic runs in one clock domain. Bit timing comes from a clock-enable count of `CLK_HZ/BAUD` system clocks per bit; no divided clock is generated. Clock frequency, line rate and the debounce counter size are parameters. The transmitter has four states. `TX_IDLE` holds the line high with ready asserted and takes the transition to `TX_START` on a request; in that same cycle it captures the byte and drives the line low. `TX_START` moves to `TX_DATA` after one bit time. `TX_DATA` stays put for eight bit times, stepping its bit index on each tick, and moves to `TX_STOP` after the last data bit. `TX_STOP` drives the line high and returns to `TX_IDLE` after one bit time, raising ready again.

Top module: `push_uart_sender`

## Requirements
- R1: A frame is a low start bit, then the eight data bits with bit 0 first, then a high stop bit. Every bit lasts exactly CLK_HZ/BAUD clock cycles.
- R2: When idle, the serial line is high and ready is high. Ready goes low in the cycle the start bit begins and stays low until the stop bit has ended.
- R3: The raw button passes through two flip-flops in series. Any difference between the two stages clears the stability counter. The debounced level copies the synchronised input only once the counter's top bit (bit DB_BITS) is set, so a button pulse shorter than 2^DB_BITS clocks causes no frame.
- R4: One press gives exactly one frame, however long the button is held, even for many frame times. Releasing the button gives no frame.
- R5: A press or release with a burst of bounce toggles still gives exactly one frame per press.
- R6: The byte is captured when the start bit begins. Changes on the data input during a frame do not alter that frame.
- R7: A press whose debounced edge arrives while a frame is in progress is dropped, not queued. No second frame follows.
- R8: Synchronous reset drives the line high, sets ready, clears the synchroniser, the debouncer counter and output, and the edge detector, and returns the transmitter to `TX_IDLE`. A frame cut by reset is abandoned.
- R9: The internal send request lasts exactly one clock per debounced rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Unsynchronised, bouncing push-button level, high when pressed |
| tx_byte | input | 8 | Character to send, sampled at the start bit |
| ser_out | output | 1 | Serial transmit line, idle high |
| ready | output | 1 | High while no frame is in progress |

## Verification
On every cycle, the embedded assertions check the following. The line level matches each state: low in start, high in stop and idle. Ready agrees with the idle state. The baud and bit counters stay in range. The debounced level cannot move before the stability counter saturates. The send request never lasts two cycles. The scenarios alone can show the end-to-end properties: one frame per bouncing press, no frame from a long hold or a short glitch, a press during a frame being dropped, byte capture despite later data changes, and recovery after a reset mid-frame. They also sweep all 256 byte values and decode each frame against the value driven.

// File: rtl/push_uart_pkg.sv
package push_uart_pkg;

    localparam int unsigned CHAR_W = 8;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_t;

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    output logic [STAGES-1:0] taps
);

    logic [STAGES-1:0] stage_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= 1'b0;
                    else     stage_q[i] <= din;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= 1'b0;
                    else     stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign taps = stage_q;

endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
    parameter int unsigned DB_BITS = 19
) (
    input  logic clk,
    input  logic rst,
    input  logic near_q,
    input  logic far_q,
    output logic level
);

    localparam int unsigned CNT_W = DB_BITS + 1;

    logic [CNT_W-1:0] settle_cnt;
    logic             moving;
    logic             settled;

    assign moving  = near_q ^ far_q;
    assign settled = settle_cnt[DB_BITS];

    always_ff @(posedge clk) begin
        if (rst) begin
            settle_cnt <= '0;
            level      <= 1'b0;
        end else if (moving) begin
            settle_cnt <= '0;
        end else if (!settled) begin
            settle_cnt <= settle_cnt + 1'b1;
        end else begin
            level <= far_q;
        end
    end

    // R3: the filtered level cannot move until the stability count saturates
    p_level_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !settled |=> $stable(level));

    // R3: a change between the stages restarts the timer
    p_restart_r3: assert property (@(posedge clk) disable iff (rst)
        moving |=> !settled);

endmodule

// File: rtl/press_edge.sv
module press_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic pulse
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    assign pulse = level & ~prev_q;

    // R9: a request never lasts more than one clock
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    // R4: a falling level never produces a request
    p_no_release_req_r4: assert property (@(posedge clk) disable iff (rst)
        !level |-> !pulse);

endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import push_uart_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int unsigned BAUD   = 9600
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [CHAR_W-1:0] data,
    output logic              line,
    output logic              ready
);

    localparam int unsigned DIV   = CLK_HZ / BAUD;
    localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int unsigned IDX_W = $clog2(CHAR_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CHAR_W - 1);

    tx_state_t         state_q;
    tx_state_t         state_d;
    logic [CNT_W-1:0]  baud_cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [CHAR_W-1:0] shreg;
    logic              tick;

    assign tick = (baud_cnt == CNT_LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (req)  state_d = TX_START;
            TX_START: if (tick) state_d = TX_DATA;
            TX_DATA:  if (tick && bit_idx == IDX_LAST) state_d = TX_STOP;
            TX_STOP:  if (tick) state_d = TX_IDLE;
            default:            state_d = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= TX_IDLE;
        else     state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            line     <= 1'b1;
            ready    <= 1'b1;
            shreg    <= '0;
            bit_idx  <= '0;
            baud_cnt <= '0;
        end else begin
            if (state_q == TX_IDLE || tick) baud_cnt <= '0;
            else                            baud_cnt <= baud_cnt + 1'b1;
            unique case (state_q)
                TX_IDLE: begin
                    if (req) begin
                        shreg <= data;
                        line  <= 1'b0;
                        ready <= 1'b0;
                    end
                end
                TX_START: begin
                    if (tick) begin
                        line    <= shreg[0];
                        shreg   <= shreg >> 1;
                        bit_idx <= '0;
                    end
                end
                TX_DATA: begin
                    if (tick) begin
                        if (bit_idx == IDX_LAST) begin
                            line <= 1'b1;
                        end else begin
                            line    <= shreg[0];
                            shreg   <= shreg >> 1;
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                TX_STOP: begin
                    if (tick) ready <= 1'b1;
                end
                default: begin
                    line  <= 1'b1;
                    ready <= 1'b1;
                end
            endcase
        end
    end

    // R1: start bit is low, stop bit is high
    p_start_low_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == TX_START) |-> !line);
    p_stop_high_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == TX_STOP) |-> line);
    // R1: bit timer stays below the divider
    p_baud_range_r1: assert property (@(posedge clk) disable iff (rst)
        baud_cnt <= CNT_LAST);
    // R2: idle means a high line and ready; ready tracks the idle state
    p_idle_line_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == TX_IDLE) |-> (line && ready));
    p_ready_idle_r2: assert property (@(posedge clk) disable iff (rst)
        ready == (state_q == TX_IDLE));
    // R7: a request during a frame does not disturb the state
    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
        (req && state_q == TX_DATA && !tick) |=> (state_q == TX_DATA));

endmodule

// File: rtl/push_uart_sender.sv
module push_uart_sender
    import push_uart_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned BAUD    = 9600,
    parameter int unsigned DB_BITS = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              btn_raw,
    input  logic [CHAR_W-1:0] tx_byte,
    output logic              ser_out,
    output logic              ready
);

    localparam int unsigned SYNC_STAGES = 2;

    logic [SYNC_STAGES-1:0] sync_taps;
    logic                   btn_level;
    logic                   send_req;

    btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (btn_raw),
        .taps (sync_taps)
    );

    btn_debounce #(.DB_BITS(DB_BITS)) u_db (
        .clk    (clk),
        .rst    (rst),
        .near_q (sync_taps[SYNC_STAGES-2]),
        .far_q  (sync_taps[SYNC_STAGES-1]),
        .level  (btn_level)
    );

    press_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (btn_level),
        .pulse (send_req)
    );

    uart_tx_fsm #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .req   (send_req),
        .data  (tx_byte),
        .line  (ser_out),
        .ready (ready)
    );

    // R8: the cycle after reset the line is high and ready is set
    p_reset_idle_r8: assert property (@(posedge clk)
        $past(rst) |-> (ser_out && ready));

endmodule

// File: tb/sim_push_uart_sender.sv
module sim_push_uart_sender;

    localparam int CLK_PERIOD = 10;
    localparam int T_CLK_HZ   = 1000;
    localparam int T_BAUD     = 100;
    localparam int T_DB_BITS  = 4;
    localparam int DIV        = T_CLK_HZ / T_BAUD;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       btn = 1'b0;
    logic [7:0] data = 8'h00;
    logic       ser_out;
    logic       ready;

    int checks = 0;
    int errors = 0;
    int frames = 0;
    int rst_cycles = 0;
    logic [7:0] last_byte = 8'h00;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    push_uart_sender #(.CLK_HZ(T_CLK_HZ), .BAUD(T_BAUD), .DB_BITS(T_DB_BITS)) u0 (
        .clk     (clk),
        .rst     (rst),
        .btn_raw (btn),
        .tx_byte (data),
        .ser_out (ser_out),
        .ready   (ready)
    );

    always @(posedge clk) if (rst) rst_cycles <= rst_cycles + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // bouncy press: seven toggles two cycles apart, ending high (R5)
    task automatic press();
        for (int i = 0; i < 7; i++) begin
            btn = ~btn;
            wait_n(2);
        end
        btn = 1'b1;
    endtask

    task automatic release_btn();
        for (int i = 0; i < 7; i++) begin
            btn = ~btn;
            wait_n(2);
        end
        btn = 1'b0;
    endtask

    task automatic wait_busy();
        for (int i = 0; i < 200; i++) begin
            if (!ready) break;
            @(negedge clk);
        end
    endtask

    // line monitor: decodes frames, sampling mid-bit
    initial begin
        forever begin
            logic [7:0] b;
            int r0;
            logic rdy_start, rdy_stop, stop_bit;
            @(negedge clk);
            if (rst || ser_out !== 1'b0) continue;
            r0 = rst_cycles;
            wait_n(DIV/2);
            rdy_start = ready;
            for (int k = 0; k < 8; k++) begin
                wait_n(DIV);
                b[k] = ser_out;
            end
            wait_n(DIV);
            stop_bit = ser_out;
            rdy_stop = ready;
            if (rst_cycles == r0 && !rst) begin
                chk(stop_bit === 1'b1, "R1 stop bit", int'(stop_bit), 1);
                chk(rdy_start === 1'b0 && rdy_stop === 1'b0, "R2 ready low in frame",
                    int'(rdy_start | rdy_stop), 0);
                frames++;
                last_byte = b;
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int f0;
        logic min_rdy;
        wait_n(5);
        chk(ser_out === 1'b1, "R8 line high in reset", int'(ser_out), 1);
        chk(ready === 1'b1, "R8 ready high in reset", int'(ready), 1);
        rst = 1'b0;
        wait_n(40);
        chk(ser_out === 1'b1 && ready === 1'b1, "R2 idle after reset", int'(ser_out & ready), 1);

        // sweep every byte value with a bouncy press and release (R1, R4, R5)
        for (int v = 0; v < 256; v++) begin
            data = 8'(v);
            f0 = frames;
            press();
            wait_n(40);
            release_btn();
            wait_n(220);
            chk(frames == f0 + 1, "R5 one frame per bouncy press", frames - f0, 1);
            chk(last_byte == 8'(v), "R1 decoded byte", int'(last_byte), v);
            chk(ready === 1'b1 && ser_out === 1'b1, "R2 idle after frame", int'(ready & ser_out), 1);
        end

        // short glitch below the debounce window (R3)
        f0 = frames;
        min_rdy = 1'b1;
        btn = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            min_rdy = min_rdy & ready;
        end
        btn = 1'b0;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            min_rdy = min_rdy & ready;
        end
        chk(frames == f0, "R3 glitch gives no frame", frames - f0, 0);
        chk(min_rdy === 1'b1, "R3 ready stays high on glitch", int'(min_rdy), 1);

        // long hold, about seven frame times (R4)
        data = 8'h66;
        f0 = frames;
        press();
        wait_n(700);
        chk(frames == f0 + 1, "R4 long hold one frame", frames - f0, 1);
        chk(last_byte == 8'h66, "R4 long hold byte", int'(last_byte), 8'h66);
        release_btn();
        wait_n(200);
        chk(frames == f0 + 1, "R4 release no frame", frames - f0, 1);

        // data changes mid-frame (R6)
        data = 8'hC3;
        f0 = frames;
        press();
        wait_busy();
        wait_n(3);
        data = 8'h3C;
        wait_n(20);
        release_btn();
        wait_n(250);
        chk(frames == f0 + 1, "R6 one frame", frames - f0, 1);
        chk(last_byte == 8'hC3, "R6 captured byte", int'(last_byte), 8'hC3);

        // second press while busy is dropped (R7)
        data = 8'h5E;
        f0 = frames;
        press();
        wait_busy();
        wait_n(5);
        release_btn();
        wait_n(22);
        press();
        chk(ready === 1'b0, "R7 still busy at second press", int'(ready), 0);
        wait_n(300);
        chk(frames == f0 + 1, "R7 no queued frame", frames - f0, 1);
        chk(last_byte == 8'h5E, "R7 byte", int'(last_byte), 8'h5E);
        chk(ready === 1'b1, "R7 idle after", int'(ready), 1);
        release_btn();
        wait_n(200);
        chk(frames == f0 + 1, "R7 nothing after release", frames - f0, 1);

        // reset mid-frame (R8)
        data = 8'hA5;
        f0 = frames;
        press();
        wait_busy();
        wait_n(35);
        rst = 1'b1;
        btn = 1'b0;
        wait_n(2);
        chk(ser_out === 1'b1, "R8 line high after mid-frame reset", int'(ser_out), 1);
        chk(ready === 1'b1, "R8 ready after mid-frame reset", int'(ready), 1);
        rst = 1'b0;
        wait_n(250);
        chk(frames == f0, "R8 aborted frame not completed", frames - f0, 0);
        chk(ser_out === 1'b1, "R8 line idle after reset", int'(ser_out), 1);

        // recovery after reset
        data = 8'h5A;
        f0 = frames;
        press();
        wait_n(40);
        release_btn();
        wait_n(220);
        chk(frames == f0 + 1, "R8 recovery frame", frames - f0, 1);
        chk(last_byte == 8'h5A, "R8 recovery byte", int'(last_byte), 8'h5A);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule